// File: doc/BRIEF.md
# Lagged-Response CRC-Checked SPI Master

This block is an SPI master for a peripheral that talks in fixed 32-bit frames and answers each request one frame later. A user issues a command (read or write, an 8-bit register address, 16 bits of write data and a capture flag). The block builds the request word, seals it with a 3-bit checksum and shifts it out most significant bit first. Chip select is released between frames for at least a programmed minimum time.

A write is a single frame, and no result is returned for it. A read takes two frames. The first frame carries the request, and its incoming bits are discarded. The second frame repeats a read request to the same address while collecting the reply. The reply's checksum and status bits are then checked, and the block delivers a one-cycle result strobe with the 16-bit data and an error flag.

Top module: `lagged_spi_master`

## Requirements
- R1: Each request frame holds zero in bits 31:30, the address in bits 29:22, the write flag in bit 21 (1 = write), the capture flag in bit 20 (set only for read requests), zero in bit 19, write data in bits 18:3 (zero for reads), and the checksum in bits 2:0.
- R2: The checksum is a 3-bit shift register seeded with 3'b101. It takes frame bits from bit 31 down to bit 0. At each step the old bit 2 is saved, the register shifts left with the data bit entering bit 0, and the result is XORed with 3'b011 if the saved bit was 1. The transmitted checksum is computed over the frame with bits 2:0 zero, so running the checksum over any full transmitted frame gives zero.
- R3: A read produces exactly two frames. The second frame is a read request to the same address with the capture flag clear. Exactly one result strobe follows, one clock after chip select rises at the end of the second frame.
- R4: A write produces exactly one frame and no result strobe.
- R5: When the reply frame's checksum over all 32 bits is zero, and bits 31 and 3 are not both 1, rsp_error is 0 and rsp_data equals reply bits 19:4.
- R6: A reply whose 32-bit checksum is nonzero raises rsp_error with the result strobe.
- R7: A reply with bits 31 and 3 both 1 raises rsp_error. A reply with only one of those two bits set and a good checksum is accepted without error.
- R8: Between frames, chip select stays high for more than MIN_GAP_NS. That is at least MIN_GAP_NS/CLK_PERIOD_NS + 1 clock cycles (71 at the defaults).
- R9: The serial clock idles low and stays low while chip select is high. Each frame has exactly 32 rising edges. MOSI changes after falling edges, and MISO is sampled on rising edges.
- R10: cmd_ready is low while a command is in progress, including the chip-select gap between the two frames of a read. A command is taken only on a cycle where cmd_valid and cmd_ready are both high.
- R11: After reset, chip select is high, the serial clock is low, rsp_valid is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_capture | input | 1 | Capture flag for a read request |
| rsp_valid | output | 1 | One-cycle result strobe for reads |
| rsp_data | output | 16 | Read data, don't-care when rsp_error is 1 |
| rsp_error | output | 1 | Reply failed its checksum or status check |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
Several internal faults show up at the ports at a predictable time:
- A shift counter or divider fault changes the number of rising edges in a frame and corrupts the word the peripheral model assembles. It is caught when chip select rises at the end of that frame.
- A gap counter fault shortens the high time of chip select. It is seen at the next falling edge of chip select.
- A controller state fault shows up in one of three ways: a missing or extra second frame, a result strobe after a write, or cmd_ready high during the gap between the two frames of a read. Each of these is visible within one frame time.
- A checksum fault either seals request frames wrongly, which shows up on the first frame sent, or misjudges replies. The latter appears on the first result strobe fed with deliberately damaged replies.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int FRAME_W      = 32;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 16;
    localparam int CRC_W        = 3;

    // field positions inside a frame; the peripheral decodes these
    localparam int POS_ADDR_LO  = 22;
    localparam int POS_WR       = 21;
    localparam int POS_CAP      = 20;
    localparam int POS_WDATA_LO = 3;
    localparam int POS_RDATA_LO = 4;
    localparam int POS_STAT_HI  = 31;
    localparam int POS_STAT_LO  = 3;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_FIRST,
        CTL_HOLD,
        CTL_SECOND
    } ctl_state_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_GAP
    } eng_state_e;

    // request word with the checksum bits left at zero
    function automatic logic [FRAME_W-1:0] pack_request(
        input logic              wr,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] wdata,
        input logic              cap
    );
        logic [FRAME_W-1:0] f;
        f = '0;
        f[POS_ADDR_LO +: ADDR_W]  = addr;
        f[POS_WR]                 = wr;
        f[POS_CAP]                = cap;
        f[POS_WDATA_LO +: DATA_W] = wdata;
        return f;
    endfunction

endpackage

// File: rtl/lsm_crc3.sv
module lsm_crc3 import lsm_pkg::*; #(
    parameter int               WIDTH = 32,
    parameter logic [CRC_W-1:0] SEED  = 3'b101,
    parameter logic [CRC_W-1:0] POLY  = 3'b011
) (
    input  logic [WIDTH-1:0] data_i,
    output logic [CRC_W-1:0] crc_o
);

    // fully unrolled serial checksum, MSB of the word enters first
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = SEED;
        fb  = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1];
            acc = {acc[CRC_W-2:0], data_i[i]};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end

endmodule

// File: rtl/lsm_frame_engine.sv
module lsm_frame_engine import lsm_pkg::*; #(
    parameter int SCLK_HALF = 2,
    parameter int GAP_CYC   = 71
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] tx_i,
    output logic               ready_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] rx_o,
    output logic               sclk_o,
    output logic               cs_n_o,
    output logic               mosi_o,
    input  logic               miso_i
);

    localparam int BIT_W = $clog2(FRAME_W);
    localparam int DIV_W = $clog2(SCLK_HALF + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    typedef struct packed {
        eng_state_e         st;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [BIT_W-1:0]   bits;
        logic [DIV_W-1:0]   div;
        logic [GAP_W-1:0]   gap;
        logic               sclk;
        logic               cs_n;
        logic               done;
    } eng_t;

    localparam eng_t ENG_RST = '{
        st:   ENG_IDLE,
        tx:   '0,
        rx:   '0,
        bits: '0,
        div:  '0,
        gap:  '0,
        sclk: 1'b0,
        cs_n: 1'b1,
        done: 1'b0
    };

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (start_i) begin
                    eng_d.st   = ENG_SHIFT;
                    eng_d.tx   = tx_i;
                    eng_d.bits = '0;
                    eng_d.div  = '0;
                    eng_d.sclk = 1'b0;
                    eng_d.cs_n = 1'b0;
                end
            end
            ENG_SHIFT: begin
                if (eng_q.div == DIV_W'(SCLK_HALF - 1)) begin
                    eng_d.div = '0;
                    if (!eng_q.sclk) begin
                        // rising edge: take one reply bit
                        eng_d.sclk = 1'b1;
                        eng_d.rx   = {eng_q.rx[FRAME_W-2:0], miso_i};
                    end else begin
                        // falling edge: next bit or end of frame
                        eng_d.sclk = 1'b0;
                        if (eng_q.bits == BIT_W'(FRAME_W - 1)) begin
                            eng_d.st   = ENG_GAP;
                            eng_d.cs_n = 1'b1;
                            eng_d.done = 1'b1;
                            eng_d.gap  = GAP_W'(GAP_CYC);
                        end else begin
                            eng_d.bits = eng_q.bits + 1'b1;
                            eng_d.tx   = {eng_q.tx[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    eng_d.div = eng_q.div + 1'b1;
                end
            end
            ENG_GAP: begin
                if (eng_q.gap <= GAP_W'(1)) begin
                    eng_d.st = ENG_IDLE;
                end else begin
                    eng_d.gap = eng_q.gap - 1'b1;
                end
            end
            default: eng_d = ENG_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= ENG_RST;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign ready_o = (eng_q.st == ENG_IDLE);
    assign done_o  = eng_q.done;
    assign rx_o    = eng_q.rx;
    assign sclk_o  = eng_q.sclk;
    assign cs_n_o  = eng_q.cs_n;
    assign mosi_o  = eng_q.tx[FRAME_W-1];

endmodule

// File: rtl/lagged_spi_master.sv
module lagged_spi_master import lsm_pkg::*; #(
    parameter int CLK_PERIOD_NS = 10,
    parameter int MIN_GAP_NS    = 700,
    parameter int SCLK_HALF     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_capture,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_error,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    // strictly longer than the minimum high time of chip select
    localparam int GAP_CYC = MIN_GAP_NS / CLK_PERIOD_NS + 1;

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              rsp_v;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:       CTL_IDLE,
        addr:     '0,
        wr:       1'b0,
        rsp_v:    1'b0,
        rsp_err:  1'b0,
        rsp_data: '0
    };

    ctl_t ctl_d, ctl_q;

    logic               eng_start;
    logic               eng_ready;
    logic               eng_done;
    logic [FRAME_W-1:0] eng_rx;
    logic [FRAME_W-1:0] tx_base;
    logic [CRC_W-1:0]   tx_crc;
    logic [CRC_W-1:0]   rx_crc;
    logic               stat_bad;

    lsm_crc3 #(.WIDTH(FRAME_W)) u_tx_crc (
        .data_i (tx_base),
        .crc_o  (tx_crc)
    );

    lsm_crc3 #(.WIDTH(FRAME_W)) u_rx_crc (
        .data_i (eng_rx),
        .crc_o  (rx_crc)
    );

    lsm_frame_engine #(
        .SCLK_HALF (SCLK_HALF),
        .GAP_CYC   (GAP_CYC)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .tx_i    ({tx_base[FRAME_W-1:CRC_W], tx_crc}),
        .ready_o (eng_ready),
        .done_o  (eng_done),
        .rx_o    (eng_rx),
        .sclk_o  (spi_sclk),
        .cs_n_o  (spi_cs_n),
        .mosi_o  (spi_mosi),
        .miso_i  (spi_miso)
    );

    assign stat_bad = eng_rx[POS_STAT_HI] & eng_rx[POS_STAT_LO];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        eng_start   = 1'b0;
        cmd_ready   = (ctl_q.st == CTL_IDLE) && eng_ready;
        // second frame of a read: plain read of the stored address
        tx_base     = pack_request(1'b0, ctl_q.addr, '0, 1'b0);
        unique case (ctl_q.st)
            CTL_IDLE: begin
                tx_base = pack_request(cmd_write, cmd_addr,
                                       cmd_write ? cmd_wdata : '0,
                                       !cmd_write && cmd_capture);
                if (cmd_valid && cmd_ready) begin
                    eng_start  = 1'b1;
                    ctl_d.addr = cmd_addr;
                    ctl_d.wr   = cmd_write;
                    ctl_d.st   = CTL_FIRST;
                end
            end
            CTL_FIRST: begin
                if (eng_done) begin
                    ctl_d.st = ctl_q.wr ? CTL_IDLE : CTL_HOLD;
                end
            end
            CTL_HOLD: begin
                if (eng_ready) begin
                    eng_start = 1'b1;
                    ctl_d.st  = CTL_SECOND;
                end
            end
            CTL_SECOND: begin
                if (eng_done) begin
                    ctl_d.rsp_v    = 1'b1;
                    ctl_d.rsp_data = eng_rx[POS_RDATA_LO +: DATA_W];
                    ctl_d.rsp_err  = (rx_crc != '0) || stat_bad;
                    ctl_d.st       = CTL_IDLE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rsp_v;
    assign rsp_data  = ctl_q.rsp_data;
    assign rsp_error = ctl_q.rsp_err;

endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
    parameter int GAP_CYC = 71
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic cmd_ready,
    input logic rsp_valid
);

    localparam int CW = $clog2(GAP_CYC + 2);

    // consecutive cycles of chip select high, saturating
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= CW'(GAP_CYC);
        end else if (cs_n) begin
            if (hi_cnt < CW'(GAP_CYC)) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_gap_long_enough_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= CW'(GAP_CYC))
    );

    assert_sclk_parked_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk
    );

    assert_busy_not_ready_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        !cs_n |-> !cmd_ready
    );

    assert_single_strobe_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid
    );

    assert_strobe_after_frame_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(cs_n) && !$past(cs_n, 2))
    );

endmodule

bind lagged_spi_master lsm_checker #(.GAP_CYC(GAP_CYC)) u_lsm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_lagged_spi_master.sv
module tb_lagged_spi_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_capture = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        rsp_error;
    logic        spi_sclk;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    always #5 clk = ~clk;

    lagged_spi_master dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_write   (cmd_write),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .cmd_capture (cmd_capture),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_error   (rsp_error),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso)
    );

    int checks = 0;
    int fails  = 0;
    int rsp_seen = 0;
    int rd_issued = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // checksum model taken from the requirement text
    function automatic logic [2:0] ref_crc(input logic [31:0] w);
        int c = 5;
        for (int i = 31; i >= 0; i--) begin
            int top = (c >> 2) & 1;
            c = ((c << 1) | int'(w[i])) & 7;
            if (top != 0) c = c ^ 3;
        end
        return 3'(c);
    endfunction

    function automatic logic [31:0] ref_frame(input logic wr, input logic [7:0] a,
                                              input logic [15:0] d, input logic cap);
        logic [31:0] f;
        f = {2'b00, a, wr, cap, 1'b0, d, 3'b000};
        f[2:0] = ref_crc(f);
        return f;
    endfunction

    // ---------------- peripheral model ----------------
    logic [15:0] mem [256];
    int          inj = 0;
    logic [31:0] slv_resp = '0;
    logic [31:0] slv_sh;
    logic [31:0] slv_rx;
    int          nrise;
    realtime     t_high;
    bit          had_frame = 0;
    logic [31:0] exp_frames [$];

    function automatic logic [31:0] mk_resp(input logic [15:0] d, input int mode);
        logic [31:0] r;
        r = {12'h000, d, 4'h0};
        if (mode == 2) begin r[31] = 1'b1; r[3] = 1'b1; end
        if (mode == 3) r[31] = 1'b1;
        if (mode == 4) r[3] = 1'b1;
        r[2:0] = ref_crc(r);
        if (mode == 1) r[10] = ~r[10];
        return r;
    endfunction

    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            if (had_frame) begin
                check(($realtime - t_high) > 700.0, "R8", "chip select gap ns",
                      32'($rtoi($realtime - t_high)), 32'd700);
            end
            slv_sh   = slv_resp;
            spi_miso = slv_sh[31];
            slv_rx   = '0;
            nrise    = 0;
        end
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            slv_rx = {slv_rx[30:0], spi_mosi};
            nrise++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            slv_sh   = {slv_sh[30:0], 1'b0};
            spi_miso = slv_sh[31];
        end
    end

    always @(posedge spi_cs_n) begin
        if (rst_n) begin
            t_high    = $realtime;
            had_frame = 1;
            check(nrise == 32, "R9", "rising edges per frame", 32'(nrise), 32'd32);
            check(ref_crc(slv_rx) == 3'b000, "R2", "checksum over sent frame",
                  32'(ref_crc(slv_rx)), 32'd0);
            if (exp_frames.size() == 0) begin
                check(1'b0, "R3", "unexpected frame", slv_rx, 32'h0);
            end else begin
                logic [31:0] ef;
                ef = exp_frames.pop_front();
                check(slv_rx == ef, "R1", "request frame", slv_rx, ef);
            end
            if (slv_rx[21]) mem[slv_rx[29:22]] = slv_rx[18:3];
            slv_resp = mk_resp(mem[slv_rx[29:22]], inj);
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_data [$];
    logic        exp_err  [$];
    string       exp_req  [$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rsp_seen++;
            if (exp_data.size() == 0) begin
                check(1'b0, "R4", "result strobe with nothing pending", 32'(rsp_data), 32'h0);
            end else begin
                logic [15:0] ed;
                logic        ee;
                string       er;
                ed = exp_data.pop_front();
                ee = exp_err.pop_front();
                er = exp_req.pop_front();
                check(rsp_error == ee, er, "error flag", 32'(rsp_error), 32'(ee));
                if (!ee) check(rsp_data == ed, er, "read data", 32'(rsp_data), 32'(ed));
            end
        end
    end

    task automatic send(input logic wr, input logic [7:0] a, input logic [15:0] d, input logic cap);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_capture = cap;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        exp_frames.push_back(ref_frame(1'b1, a, d, 1'b0));
        send(1'b1, a, d, 1'b0);
    endtask

    task automatic do_read(input logic [7:0] a, input logic cap, input string req);
        exp_frames.push_back(ref_frame(1'b0, a, 16'h0, cap));
        exp_frames.push_back(ref_frame(1'b0, a, 16'h0, 1'b0));
        exp_data.push_back(inj == 1 ? mem[a] ^ 16'h0040 : mem[a]);
        exp_err.push_back(inj == 1 || inj == 2);
        exp_req.push_back(req);
        rd_issued++;
        send(1'b0, a, 16'h0, cap);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_frames.size() != 0 || exp_data.size() != 0 || !cmd_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0103) ^ 16'h5A5A;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(spi_cs_n == 1'b1, "R11", "cs_n after reset", 32'(spi_cs_n), 32'd1);
        check(spi_sclk == 1'b0, "R11", "sclk after reset", 32'(spi_sclk), 32'd0);
        check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", 32'(cmd_ready), 32'd1);

        // R5 plain reads, R1 capture flag on first frame only
        do_read(8'h10, 1'b0, "R5");
        do_read(8'h00, 1'b1, "R1");
        wait_idle();

        // R4 writes followed by readback
        do_write(8'h22, 16'hBEEF);
        wait_idle();
        do_read(8'h22, 1'b0, "R4");
        do_write(8'hFF, 16'hFFFF);
        wait_idle();
        do_read(8'hFF, 1'b1, "R5");
        wait_idle();

        // R10 ready low inside a frame and in the gap between read frames
        do_read(8'h33, 1'b0, "R3");
        repeat (5) @(negedge clk);
        check(!cmd_ready && !spi_cs_n, "R10", "ready during first frame",
              32'(cmd_ready), 32'd0);
        @(posedge spi_cs_n);
        repeat (3) @(negedge clk);
        check(!cmd_ready && spi_cs_n, "R10", "ready in gap between read frames",
              32'(cmd_ready), 32'd0);
        wait_idle();

        // R6 damaged checksum
        inj = 1;
        do_read(8'h44, 1'b0, "R6");
        wait_idle();
        // R7 both status bits
        inj = 2;
        do_read(8'h45, 1'b0, "R7");
        wait_idle();
        // R7 single status bits are accepted
        inj = 3;
        do_read(8'h46, 1'b0, "R7");
        wait_idle();
        inj = 4;
        do_read(8'h47, 1'b0, "R7");
        wait_idle();
        inj = 0;

        // back-to-back reads
        do_read(8'h01, 1'b0, "R5");
        do_read(8'h02, 1'b1, "R5");
        do_write(8'h03, 16'h0000);
        wait_idle();
        do_read(8'h03, 1'b0, "R4");
        wait_idle();
        repeat (20) @(negedge clk);

        check(rsp_seen == rd_issued, "R4", "result strobes equal reads only",
              32'(rsp_seen), 32'(rd_issued));
        check(exp_frames.size() == 0, "R3", "all expected frames sent",
              32'(exp_frames.size()), 32'd0);
        finish_run();
    end

endmodule